// File: doc/BRIEF.md
# Windowed Independent Watchdog Timer

The block is a watchdog that counts down on its own low-frequency time base, separate from the bus clock that writes its registers. Software starts it with a key write, after which it can no longer be stopped short of a system reset. From then on software must refresh it periodically. A refresh that comes too late lets the 12-bit down-counter run out. A refresh that comes too early, while the counter is still above a programmed window threshold, is also treated as a fault. In either case the block raises a sticky system-reset request.

Three configuration values are write-protected behind an unlock key: a prescaler code, a reload value and a window threshold. Each crossing into the low-frequency domain is modelled as a fixed delay of `SYNC_TICKS` low-frequency ticks. While a value is in transit, its own busy bit in the status register stays set. Only after that bit clears does the new value steer the counter and appear on read-back.

The low-frequency clock is represented by `lf_tick`, a one-cycle enable pulse in the bus clock domain, with one pulse per low-frequency period. The register map is: 0 key (reads as 0), 1 prescaler code, 2 reload, 3 window, 4 status.

Top module: `winwdt`

## Requirements
- R1: After `rst`, `reset_req` is 0 and the registers read back as follows: prescaler 0, reload 0xFFF, window 0xFFF, status 0, key 0.
- R2: A key write (address 0) of 0xCCCC starts the watchdog. A key write of 0x5555 unlocks the configuration registers. A key write of 0xAAAA refreshes the counter. A key write of any value other than 0x5555 locks the configuration registers again. Writes to addresses 1 to 3 while locked are ignored.
- R3: The status register (address 4) holds one busy bit per configuration value: bit 0 for the prescaler, bit 1 for the reload and bit 2 for the window. An accepted write sets its bit, and the bit clears on the `SYNC_TICKS`-th `lf_tick` after the write. A write to a register whose busy bit is set is ignored.
- R4: A newly written configuration value is neither read back nor used until its busy bit has cleared; until then the previous value is in effect.
- R5: With reload value R and divisor D, `reset_req` rises on the (R+1)·D-th `lf_tick` after a start or an accepted refresh, provided no refresh comes in between.
- R6: Prescaler codes 0 to 6 divide by 4·2^code, and code 7 also divides by 256. Only the low 3 bits of a prescaler write are stored.
- R7: A refresh while running, with the counter at or below the window value, reloads the counter and restarts the prescaler phase.
- R8: A refresh while the counter is above the window value sets `reset_req` at the write's clock edge. With the window at 0xFFF no refresh is ever early.
- R9: Once started, the watchdog keeps running, and `reset_req` stays at 1 until `rst`. Neither changes in response to any key.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high system reset |
| lf_tick | input | 1 | One-cycle pulse per low-frequency watchdog clock period |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write address (0 key, 1 prescaler, 2 reload, 3 window) |
| wr_data | input | 16 | Write data |
| rd_addr | input | 3 | Read address; data appears one clock later |
| rd_data | output | 16 | Registered read data |
| reset_req | output | 1 | Sticky system-reset request |

## Verification
Timeouts are exercised with three prescaler/reload pairs: divide-by-4 with reload 10, divide-by-16 with reload 2, and code 7 with reload 1. Each pair is checked one tick before and exactly at the expected expiry, which separates an off-by-one in the counter from one in the divider, and confirms that code 7 aliases to 256. Refreshes are tried in three situations: immediately after start with a window of 5, once the counter has reached the window, and immediately with the window at 0xFFF. Together these separate the early-refresh fault, the permitted reload and the disabled check. Configuration writes are tried while locked, after a relocking key, while busy, and in pairs, to pin down the bit positions and the moment each value takes effect.

// File: rtl/winwdt_pkg.sv
package winwdt_pkg;
  localparam int unsigned ADDR_W = 3;
  localparam int unsigned DATA_W = 16;

  localparam logic [ADDR_W-1:0] A_KEY  = 3'd0;
  localparam logic [ADDR_W-1:0] A_STAT = 3'd4;

  localparam logic [DATA_W-1:0] KEY_START  = 16'hCCCC;
  localparam logic [DATA_W-1:0] KEY_UNLOCK = 16'h5555;
  localparam logic [DATA_W-1:0] KEY_FEED   = 16'hAAAA;

  // configuration slots; slot i lives at address i+1
  localparam int unsigned SLOT_PSC  = 0;
  localparam int unsigned SLOT_RLD  = 1;
  localparam int unsigned SLOT_WIN  = 2;
  localparam int unsigned NUM_SLOTS = 3;
endpackage

// File: rtl/winwdt_cfg_slot.sv
// One protected configuration value with its crossing delay and busy flag.
module winwdt_cfg_slot #(
  parameter int unsigned W          = 12,
  parameter logic [W-1:0] RST_VAL   = '0,
  parameter int unsigned SYNC_TICKS = 5
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tick,
  input  logic         wr,
  input  logic [W-1:0] din,
  output logic [W-1:0] eff,
  output logic         busy
);
  localparam int unsigned DLY_W = $clog2(SYNC_TICKS + 1);

  logic [W-1:0]     shadow;
  logic [DLY_W-1:0] dly;

  always_ff @(posedge clk) begin
    if (rst) begin
      shadow <= RST_VAL;
      eff    <= RST_VAL;
      busy   <= 1'b0;
      dly    <= '0;
    end else if (wr && !busy) begin
      shadow <= din;
      busy   <= 1'b1;
      dly    <= DLY_W'(SYNC_TICKS);
    end else if (busy && tick) begin
      if (dly == DLY_W'(1)) begin
        busy <= 1'b0;
        eff  <= shadow;
      end else begin
        dly <= dly - 1'b1;
      end
    end
  end
endmodule

// File: rtl/winwdt_prescaler.sv
// Divides the low-frequency tick by 4 << min(code, 2^PSC_W - 2).
module winwdt_prescaler #(
  parameter int unsigned PSC_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             run,
  input  logic             restart,
  input  logic [PSC_W-1:0] code,
  output logic             step
);
  localparam int unsigned MAX_SHIFT = (1 << PSC_W) - 2;
  localparam int unsigned PC_W      = MAX_SHIFT + 2;

  logic [PSC_W-1:0] shift;
  logic [PC_W:0]    span;
  logic [PC_W-1:0]  last;
  logic [PC_W-1:0]  pc;
  logic             at_last;

  always_comb begin
    shift   = (code > PSC_W'(MAX_SHIFT)) ? PSC_W'(MAX_SHIFT) : code;
    span    = (PC_W+1)'(1) << (int'(shift) + 2);
    last    = PC_W'(span - (PC_W+1)'(1));
    at_last = (pc >= last);
    step    = run && tick && !restart && at_last;
  end

  always_ff @(posedge clk) begin
    if (rst || restart || !run) begin
      pc <= '0;
    end else if (tick) begin
      pc <= at_last ? '0 : pc + 1'b1;
    end
  end
endmodule

// File: rtl/winwdt_counter.sv
// Down-counter with load priority; flags expiry on a step at zero.
module winwdt_counter #(
  parameter int unsigned CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] reload,
  input  logic             step,
  output logic [CNT_W-1:0] cnt,
  output logic             expire
);
  assign expire = step && (cnt == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '1;
    end else if (load) begin
      cnt <= reload;
    end else if (step && cnt != '0) begin
      cnt <= cnt - 1'b1;
    end
  end
endmodule

// File: rtl/winwdt.sv
module winwdt
  import winwdt_pkg::*;
#(
  parameter int unsigned CNT_W      = 12,
  parameter int unsigned PSC_W      = 3,
  parameter int unsigned SYNC_TICKS = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              lf_tick,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              reset_req
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic                 unlocked;
  logic                 running;
  logic                 key_wr, start_k, feed_k;
  logic                 feed_ok, early, load, step, expire;
  logic [NUM_SLOTS-1:0] slot_wr;
  logic [NUM_SLOTS-1:0] busy;
  logic [CNT_W-1:0]     slot_din [NUM_SLOTS];
  logic [CNT_W-1:0]     slot_eff [NUM_SLOTS];
  logic [CNT_W-1:0]     cnt;
  logic [CNT_W-1:0]     rld_eff, win_eff;
  logic [PSC_W-1:0]     psc_code;

  assign key_wr  = wr_en && (wr_addr == A_KEY);
  assign start_k = key_wr && (wr_data == KEY_START);
  assign feed_k  = key_wr && (wr_data == KEY_FEED);

  genvar g;
  generate
    for (g = 0; g < NUM_SLOTS; g++) begin : g_slot
      localparam logic [ADDR_W-1:0] SLOT_ADDR = ADDR_W'(g + 1);
      localparam logic [CNT_W-1:0]  RV        = (g == SLOT_PSC) ? '0 : CNT_MAX;

      assign slot_wr[g]  = wr_en && unlocked && (wr_addr == SLOT_ADDR);
      assign slot_din[g] = (g == SLOT_PSC) ? CNT_W'(wr_data[PSC_W-1:0])
                                           : wr_data[CNT_W-1:0];

      winwdt_cfg_slot #(
        .W(CNT_W), .RST_VAL(RV), .SYNC_TICKS(SYNC_TICKS)
      ) u_slot (
        .clk(clk), .rst(rst), .tick(lf_tick), .wr(slot_wr[g]),
        .din(slot_din[g]), .eff(slot_eff[g]), .busy(busy[g])
      );
    end
  endgenerate

  assign rld_eff  = slot_eff[SLOT_RLD];
  assign win_eff  = slot_eff[SLOT_WIN];
  assign psc_code = slot_eff[SLOT_PSC][PSC_W-1:0];

  assign early   = feed_k && running && (cnt > win_eff);
  assign feed_ok = feed_k && running && !(cnt > win_eff);
  assign load    = (start_k && !running) || feed_ok;

  winwdt_prescaler #(.PSC_W(PSC_W)) u_psc (
    .clk(clk), .rst(rst), .tick(lf_tick), .run(running),
    .restart(load), .code(psc_code), .step(step)
  );

  winwdt_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .load(load), .reload(rld_eff),
    .step(step), .cnt(cnt), .expire(expire)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      unlocked  <= 1'b0;
      running   <= 1'b0;
      reset_req <= 1'b0;
    end else begin
      if (key_wr)          unlocked  <= (wr_data == KEY_UNLOCK);
      if (start_k)         running   <= 1'b1;
      if (expire || early) reset_req <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
    end else begin
      rd_data <= '0;
      if (rd_addr == A_STAT) begin
        rd_data <= DATA_W'(busy);
      end else begin
        for (int i = 0; i < NUM_SLOTS; i++) begin
          if (rd_addr == ADDR_W'(i + 1)) rd_data <= DATA_W'(slot_eff[i]);
        end
      end
    end
  end
endmodule

// File: rtl/winwdt_chk.sv
module winwdt_chk #(
  parameter int unsigned NS    = 3,
  parameter int unsigned CNT_W = 12
) (
  input logic             clk,
  input logic             rst,
  input logic             lf_tick,
  input logic             wr_en,
  input logic             reset_req,
  input logic             running,
  input logic             unlocked,
  input logic [NS-1:0]    busy,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] rld_eff
);
  logic past_ok = 1'b0;
  always_ff @(posedge clk) past_ok <= past_ok | rst;

  // R9
  req_sticky_chk: assert property (@(posedge clk) disable iff (rst || !past_ok)
    reset_req |=> reset_req);

  // R9
  run_sticky_chk: assert property (@(posedge clk) disable iff (rst || !past_ok)
    running |=> running);

  // R5
  cnt_hold_chk: assert property (@(posedge clk) disable iff (rst || !past_ok)
    (!lf_tick && !wr_en) |=> $stable(cnt));

  // R4
  rld_hold_chk: assert property (@(posedge clk) disable iff (rst || !past_ok)
    !$fell(busy[1]) |-> $stable(rld_eff));

  genvar g;
  generate
    for (g = 0; g < NS; g++) begin : g_busy
      // R3
      busy_rise_chk: assert property (@(posedge clk) disable iff (rst || !past_ok)
        $rose(busy[g]) |-> ($past(wr_en) && $past(unlocked)));
    end
  endgenerate
endmodule

bind winwdt winwdt_chk #(.NS(winwdt_pkg::NUM_SLOTS), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .lf_tick(lf_tick), .wr_en(wr_en),
  .reset_req(reset_req), .running(running), .unlocked(unlocked),
  .busy(busy), .cnt(cnt), .rld_eff(rld_eff)
);

// File: tb/winwdt_tb.sv
module winwdt_tb;
  import winwdt_pkg::*;

  localparam int SYNC = 5;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              lf_tick = 1'b0;
  logic              wr_en = 1'b0;
  logic [ADDR_W-1:0] wr_addr = '0;
  logic [DATA_W-1:0] wr_data = '0;
  logic [ADDR_W-1:0] rd_addr = '0;
  logic [DATA_W-1:0] rd_data;
  logic              reset_req;

  int n_chk = 0;
  int n_fail = 0;
  int tick_n = 0;
  int tc = 0;
  int t0;
  logic rd_req = 1'b0;
  logic rd_req_q = 1'b0;
  logic done = 1'b0;

  typedef struct { logic [DATA_W-1:0] v; string tag; } exp_t;
  exp_t q[$];

  winwdt #(.SYNC_TICKS(SYNC)) u_dut (
    .clk(clk), .rst(rst), .lf_tick(lf_tick), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
    .rd_data(rd_data), .reset_req(reset_req)
  );

  always #2 clk = ~clk;

  always @(negedge clk) begin
    tc = (tc + 1) % 4;
    lf_tick = (tc == 0);
  end

  always @(posedge clk) begin
    if (lf_tick) tick_n++;
    rd_req_q <= rd_req;
  end

  task automatic chk(string tag, logic [DATA_W-1:0] act, logic [DATA_W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rd_req_q) begin
      if (q.size() == 0) chk("scoreboard underflow", 16'h1, 16'h0);
      else begin
        exp_t e;
        e = q.pop_front();
        chk(e.tag, rd_data, e.v);
      end
    end
  end

  task automatic do_read(logic [ADDR_W-1:0] a, logic [DATA_W-1:0] v, string tag);
    exp_t e;
    e.v = v; e.tag = tag;
    q.push_back(e);
    rd_addr = a;
    rd_req = 1'b1;
    @(negedge clk);
    rd_req = 1'b0;
  endtask

  task automatic wr(logic [ADDR_W-1:0] a, logic [DATA_W-1:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_until(int t);
    while (tick_n < t) @(negedge clk);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic setup(logic [DATA_W-1:0] psc, logic [DATA_W-1:0] rld, logic [DATA_W-1:0] win);
    do_reset();
    wr(A_KEY, KEY_UNLOCK);
    wr(3'd1, psc);
    wr(3'd2, rld);
    wr(3'd3, win);
    t0 = tick_n;
    wait_until(t0 + SYNC + 1);
  endtask

  task automatic timeout_case(logic [DATA_W-1:0] psc, logic [DATA_W-1:0] rld, int n, string tag);
    setup(psc, rld, 16'hFFF);
    wr(A_KEY, KEY_START);
    t0 = tick_n;
    wait_until(t0 + n - 1);
    chk({tag, " one tick early"}, 16'(reset_req), 16'h0);
    wait_until(t0 + n);
    chk({tag, " at expiry"}, 16'(reset_req), 16'h1);
  endtask

  initial begin
    @(negedge clk);
    do_reset();
    // R1 reset state
    chk("R1 reset_req", 16'(reset_req), 16'h0);
    do_read(3'd1, 16'h0000, "R1 prescaler reset");
    do_read(3'd2, 16'h0FFF, "R1 reload reset");
    do_read(3'd3, 16'h0FFF, "R1 window reset");
    do_read(A_STAT, 16'h0000, "R1 status reset");
    do_read(A_KEY, 16'h0000, "R1 key reads zero");

    // R2 locked writes ignored, relock by another key
    wr(3'd2, 16'h0003);
    do_read(A_STAT, 16'h0000, "R2 locked write no busy");
    do_read(3'd2, 16'h0FFF, "R2 locked write ignored");
    wr(A_KEY, KEY_UNLOCK);
    wr(A_KEY, 16'h1234);
    wr(3'd2, 16'h0003);
    do_read(A_STAT, 16'h0000, "R2 relocked no busy");

    // R3/R4 busy timing, write-while-busy ignored
    wr(A_KEY, KEY_UNLOCK);
    wr(3'd2, 16'h0007);
    t0 = tick_n;
    do_read(A_STAT, 16'h0002, "R3 reload busy bit1");
    wr(3'd2, 16'h0009);
    wait_until(t0 + SYNC - 1);
    do_read(A_STAT, 16'h0002, "R3 busy before last tick");
    do_read(3'd2, 16'h0FFF, "R4 old reload until busy clears");
    wait_until(t0 + SYNC);
    do_read(A_STAT, 16'h0000, "R3 busy cleared");
    do_read(3'd2, 16'h0007, "R3 write while busy ignored / R4 new value");

    // R3/R6 bit positions and prescaler masking
    wr(3'd1, 16'hFFFA);
    do_read(A_STAT, 16'h0001, "R3 prescaler busy bit0");
    wr(3'd3, 16'h0100);
    t0 = tick_n;
    do_read(A_STAT, 16'h0005, "R3 prescaler+window bits0,2");
    wait_until(t0 + SYNC + 1);
    do_read(A_STAT, 16'h0000, "R3 all clear");
    do_read(3'd1, 16'h0002, "R6 prescaler low bits stored");
    do_read(3'd3, 16'h0100, "R4 window applied");

    // R5 timeouts, R6 divisors
    timeout_case(16'h0, 16'd10, 44, "R5 div4 reload10");
    wr(A_KEY, KEY_FEED);
    wr(A_KEY, 16'h0000);
    repeat (20) @(negedge clk);
    chk("R9 reset_req sticky", 16'(reset_req), 16'h1);
    timeout_case(16'h2, 16'd2, 48, "R6 div16 reload2");
    // R9 stop attempts after start have no effect
    setup(16'h7, 16'd1, 16'hFFF);
    wr(A_KEY, KEY_START);
    t0 = tick_n;
    wr(A_KEY, 16'h0000);
    wr(A_KEY, KEY_UNLOCK);
    wr(A_KEY, KEY_START);
    wait_until(t0 + 511);
    chk("R6 code7 div256 early / R9", 16'(reset_req), 16'h0);
    wait_until(t0 + 512);
    chk("R6 code7 div256 expiry / R9 no stop", 16'(reset_req), 16'h1);

    // R8 early refresh
    setup(16'h0, 16'd20, 16'd5);
    wr(A_KEY, KEY_START);
    chk("R8 before refresh", 16'(reset_req), 16'h0);
    wr(A_KEY, KEY_FEED);
    chk("R8 early refresh resets", 16'(reset_req), 16'h1);

    // R7 refresh inside window
    setup(16'h0, 16'd20, 16'd5);
    wr(A_KEY, KEY_START);
    t0 = tick_n;
    wait_until(t0 + 60);
    wr(A_KEY, KEY_FEED);
    t0 = tick_n;
    chk("R7 refresh in window accepted", 16'(reset_req), 16'h0);
    wait_until(t0 + 83);
    chk("R7 reload restarted", 16'(reset_req), 16'h0);
    wait_until(t0 + 84);
    chk("R7 expiry after refresh", 16'(reset_req), 16'h1);

    // R8 window 0xFFF disables early check
    setup(16'h0, 16'd20, 16'hFFF);
    wr(A_KEY, KEY_START);
    wr(A_KEY, KEY_FEED);
    t0 = tick_n;
    chk("R8 window FFF no early reset", 16'(reset_req), 16'h0);
    wait_until(t0 + 84);
    chk("R8 refresh reloaded", 16'(reset_req), 16'h1);

    repeat (4) @(negedge clk);
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule